// File: doc/BRIEF.md
# Flash Configuration Word Programming Sequencer

This block is a host-side SPI master that writes a 16-bit configuration word into a serial flash device and then reads it back to confirm it. A single-cycle start pulse launches it. The caller gives an address-mode choice (3-byte or 4-byte), a requested dummy-clock count and a flag that asks for the default count. The block builds the word from these inputs and fixed constant bits. It then runs three chip-select frames: a write-enable command, a register write, and a register read-back.

The read-back word is compared with the word that was written. One cycle after the last frame closes, the block raises done for a single cycle and holds pass or fail until the next start. A dummy request that cannot be encoded is refused. In that case a single-cycle error pulse is raised and no frame is started. Between frames, chip select stays high for a minimum number of system clocks that the user sets. The serial clock is derived from the system clock by a parameterized divider.

Top module: `cfg_reg_prog`

## Requirements
- R1: An accepted start produces exactly three chip-select frames in this order: an 8-clock frame carrying opcode 06h, a 24-clock frame starting with opcode B1h, then a 24-clock frame starting with opcode B5h.
- R2: The written word, bit 15 down to bit 0, is 1110 111y dddd 1111. Bits 15..9 and bits 3..0 are always these constants.
- R3: Bit 8 (y) is 1 when addr_4byte_i is 0 (3-byte addressing) and 0 when addr_4byte_i is 1.
- R4: Bits 7..4 (dddd) equal the request when use_default_i is 0 and the request is 1 to 14. When use_default_i is 1 they are 1111, whatever the request.
- R5: When use_default_i is 0 and the request is 0 or greater than 14, err_o pulses high for exactly one cycle after the start edge, chip select never falls, and done_o stays low.
- R6: The write frame sends, each byte MSB first, the opcode, then word bits 7..0, then word bits 15..8.
- R7: The read-back frame lasts exactly 24 serial clocks. The first 8 data bits received are word bits 7..0 (MSB first) and the next 8 are bits 15..8; the block reassembles them in that order.
- R8: pass_o=1, fail_o=0 when the read-back equals the written word, and pass_o=0, fail_o=1 otherwise. Both are held until the next start, which clears them. They are never high together.
- R9: done_o is high for exactly one cycle at the end of an accepted sequence.
- R10: Chip select stays high for at least GAP_CYCLES system clocks between consecutive frames.
- R11: The serial clock is low whenever chip select is high. DATA0 changes only while the serial clock is low, and DATA1 is sampled on the rising serial clock edge.
- R12: A start pulse that arrives while a sequence is running is ignored: it adds no frame and does not change the written word.
- R13: After reset, chip select is high, the serial clock is low, and done_o, pass_o, fail_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle launch pulse |
| addr_4byte_i | input | 1 | 1 selects 4-byte addressing, 0 selects 3-byte |
| use_default_i | input | 1 | Encode the default dummy count |
| dummy_req_i | input | DREQ_W | Requested dummy-clock count |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the flash (DATA0) |
| spi_miso_i | input | 1 | Serial data from the flash (DATA1) |
| done_o | output | 1 | End-of-sequence pulse |
| pass_o | output | 1 | Read-back matched |
| fail_o | output | 1 | Read-back mismatched |
| err_o | output | 1 | Request refused pulse |

## Verification
The embedded assertions check the following on every cycle:
- the serial clock idles low and DATA0 stays stable while the serial clock is high;
- pass and fail are never high together;
- done and err are single-cycle pulses, and a refusal never opens a frame;
- chip select stays high for at least GAP_CYCLES clocks between frames.

The bench scenarios cover what no single cycle can show. A behavioural flash model sweeps both address modes, every request value and both settings of the default flag. Against that model the bench checks:
- the frame order and opcodes;
- the exact word stored by the model and its byte order;
- the read-back reassembly;
- fail detection, using a corrupted read-back;
- that a start arriving mid-run is ignored.

// File: rtl/cfg_reg_prog_pkg.sv
package cfg_reg_prog_pkg;
  localparam int FRAME_W = 24;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRCFG = 8'hB1;
  localparam logic [7:0] OP_RDCFG = 8'hB5;
  localparam logic [3:0] DUMMY_DEFAULT = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WREN, ST_GAP1, ST_WRITE, ST_GAP2, ST_READ
  } seq_state_e;
endpackage

// File: rtl/cfg_word_build.sv
module cfg_word_build
  import cfg_reg_prog_pkg::*;
#(
  parameter int DREQ_W = 5
) (
  input  logic              addr_4byte_i,
  input  logic              use_default_i,
  input  logic [DREQ_W-1:0] dummy_req_i,
  output logic [15:0]       word_o,
  output logic              valid_o
);
  localparam logic [DREQ_W-1:0] REQ_MAX = DREQ_W'(14);

  logic [3:0] dummy_code;

  always_comb begin
    valid_o    = use_default_i || ((dummy_req_i != '0) && (dummy_req_i <= REQ_MAX));
    dummy_code = use_default_i ? DUMMY_DEFAULT : dummy_req_i[3:0];
    word_o     = {4'b1110, 3'b111, ~addr_4byte_i, dummy_code, 4'b1111};
  end
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame #(
  parameter int CLK_DIV = 2,
  parameter int FRAME_W = 24,
  localparam int LEN_W = $clog2(FRAME_W + 1),
  localparam int DIV_W = $clog2(CLK_DIV + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [FRAME_W-1:0] tx_i,
  input  logic               miso_i,
  output logic               cs_no,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o
);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic               busy_q;
  logic               sclk_q;
  logic [DIV_W-1:0]   div_q;
  logic [LEN_W-1:0]   bit_q, len_q;
  logic [FRAME_W-1:0] tx_q, rx_q;
  logic               done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      len_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          sclk_q <= 1'b0;
          div_q  <= '0;
          bit_q  <= '0;
          len_q  <= len_i;
          tx_q   <= tx_i;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sclk_q) begin
          // rising edge: capture DATA1
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[FRAME_W-2:0], miso_i};
          bit_q  <= bit_q + 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == len_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign cs_no  = ~busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[FRAME_W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  a_r11_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r11_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  a_r7_bit_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bit_q <= len_q));
endmodule

// File: rtl/cfg_reg_prog.sv
module cfg_reg_prog
  import cfg_reg_prog_pkg::*;
#(
  parameter int DREQ_W     = 5,
  parameter int CLK_DIV    = 2,
  parameter int GAP_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              addr_4byte_i,
  input  logic              use_default_i,
  input  logic [DREQ_W-1:0] dummy_req_i,
  output logic              spi_cs_no,
  output logic              spi_sclk_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              err_o
);
  localparam int LEN_W = $clog2(FRAME_W + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

  seq_state_e         state_q;
  logic [15:0]        word, word_q;
  logic               word_ok;
  logic [GAP_W-1:0]   gap_q;
  logic               eng_start_q, eng_done;
  logic [LEN_W-1:0]   eng_len;
  logic [FRAME_W-1:0] eng_tx, eng_rx;
  logic [15:0]        readback;
  logic               done_q, pass_q, fail_q, err_q;

  cfg_word_build #(.DREQ_W(DREQ_W)) u_word (
    .addr_4byte_i (addr_4byte_i),
    .use_default_i(use_default_i),
    .dummy_req_i  (dummy_req_i),
    .word_o       (word),
    .valid_o      (word_ok)
  );

  always_comb begin
    eng_len = LEN_W'(FRAME_W);
    eng_tx  = {OP_RDCFG, 16'h0000};
    unique case (state_q)
      ST_WREN: begin
        eng_len = LEN_W'(8);
        eng_tx  = {OP_WREN, 16'h0000};
      end
      ST_WRITE: eng_tx = {OP_WRCFG, word_q[7:0], word_q[15:8]};
      default: ;
    endcase
  end

  cfg_spi_frame #(.CLK_DIV(CLK_DIV), .FRAME_W(FRAME_W)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start_q),
    .len_i  (eng_len),
    .tx_i   (eng_tx),
    .miso_i (spi_miso_i),
    .cs_no  (spi_cs_no),
    .sclk_o (spi_sclk_o),
    .mosi_o (spi_mosi_o),
    .done_o (eng_done),
    .rx_o   (eng_rx)
  );

  // low byte arrives first
  assign readback = {eng_rx[7:0], eng_rx[15:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      word_q      <= '0;
      gap_q       <= '0;
      eng_start_q <= 1'b0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      eng_start_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pass_q <= 1'b0;
          fail_q <= 1'b0;
          if (!word_ok) begin
            err_q <= 1'b1;
          end else begin
            word_q      <= word;
            state_q     <= ST_WREN;
            eng_start_q <= 1'b1;
          end
        end
        ST_WREN: if (eng_done) begin
          state_q <= ST_GAP1;
          gap_q   <= '0;
        end
        ST_GAP1: if (gap_q == GAP_LAST) begin
          state_q     <= ST_WRITE;
          eng_start_q <= 1'b1;
        end else gap_q <= gap_q + 1'b1;
        ST_WRITE: if (eng_done) begin
          state_q <= ST_GAP2;
          gap_q   <= '0;
        end
        ST_GAP2: if (gap_q == GAP_LAST) begin
          state_q     <= ST_READ;
          eng_start_q <= 1'b1;
        end else gap_q <= gap_q + 1'b1;
        ST_READ: if (eng_done) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          pass_q  <= (readback == word_q);
          fail_q  <= (readback != word_q);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign err_o  = err_q;

  // chip-select high-time monitor for the gap check
  logic [GAP_W:0] hi_q;
  logic           seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      if (!spi_cs_no) begin
        hi_q   <= '0;
        seen_q <= 1'b1;
      end else if (hi_q < (GAP_W+1)'(GAP_CYCLES)) begin
        hi_q <= hi_q + 1'b1;
      end
    end
  end

  a_r10_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(spi_cs_no) && seen_q) |-> (hi_q >= (GAP_W+1)'(GAP_CYCLES)));
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_pass_fail_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
  a_r5_err_no_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (spi_cs_no && !done_o));
  a_r5_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (!err_o && spi_cs_no));
endmodule

// File: tb/test_cfg_reg_prog.sv
module test_cfg_reg_prog;
  localparam int DREQ_W = 5;
  localparam int GAP_CYCLES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, addr4 = 1'b0, dflt = 1'b0;
  logic [DREQ_W-1:0] req = '0;
  logic cs_n, sclk, mosi, done, pass, fail, err;
  logic miso = 1'b0;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cfg_reg_prog #(.DREQ_W(DREQ_W), .CLK_DIV(2), .GAP_CYCLES(GAP_CYCLES)) i_cfg_reg_prog (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_4byte_i(addr4),
    .use_default_i(dflt), .dummy_req_i(req), .spi_cs_no(cs_n), .spi_sclk_o(sclk),
    .spi_mosi_o(mosi), .spi_miso_i(miso), .done_o(done), .pass_o(pass),
    .fail_o(fail), .err_o(err)
  );

  // flash model
  logic [23:0] s_sh;
  int          s_bits;
  logic        s_rd;
  logic [15:0] s_reg;
  logic [15:0] s_cmask = 16'h0;
  bit          s_wel;
  int          f_cnt;
  logic [7:0]  f_op [0:7];
  int          f_len [0:7];

  always @(negedge cs_n) begin
    s_bits = 0; s_sh = '0; s_rd = 1'b0; miso = 1'b0;
  end

  always @(posedge sclk) if (!cs_n) begin
    logic [15:0] outw;
    int k;
    s_sh = {s_sh[22:0], mosi};
    s_bits++;
    if (s_bits == 8 && s_sh[7:0] == 8'hB5) s_rd = 1'b1;
    outw = s_reg ^ s_cmask;
    k = s_bits - 8;
    if (s_rd && k >= 0 && k < 16) miso = (k < 8) ? outw[7-k] : outw[15-(k-8)];
    else miso = 1'b0;
  end

  always @(posedge cs_n) if (s_bits > 0) begin
    logic [7:0] op;
    op = 8'(s_sh >> (s_bits - 8));
    if (f_cnt < 8) begin f_op[f_cnt] = op; f_len[f_cnt] = s_bits; end
    f_cnt++;
    if (s_bits == 8 && op == 8'h06) s_wel = 1'b1;
    if (s_bits == 24 && op == 8'hB1 && s_wel) begin
      s_reg = {s_sh[7:0], s_sh[15:8]};
      s_wel = 1'b0;
    end
    s_bits = 0;
  end

  // bus monitors sampled between edges
  int hi_run = 0, min_gap = 1000, mosi_viol = 0, idle_viol = 0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n) begin
      hi_run++;
      if (sclk) idle_viol++;
    end else begin
      if (p_cs && f_cnt > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
    if (!cs_n && sclk && p_sclk && mosi != p_mosi) mosi_viol++;
    p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic pulse_start(input bit a4, input bit d, input int r);
    @(negedge clk);
    addr4 = a4; dflt = d; req = DREQ_W'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(input bit a4, input bit d, input int r);
    logic [3:0] dd;
    dd = d ? 4'hF : 4'(r);
    return {4'b1110, 3'b111, ~a4, dd, 4'b1111};
  endfunction

  // waits for done; returns cycles waited or -1
  task automatic wait_done(output int cyc, output bit two_wide);
    cyc = -1; two_wide = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin
        cyc = i;
        @(negedge clk);
        two_wide = done;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_one(input bit a4, input bit d, input int r, input logic [15:0] cmask);
    bit valid;
    int cyc;
    bit wide;
    logic [15:0] ew;
    valid = d || (r >= 1 && r <= 14);
    ew = exp_word(a4, d, r);
    f_cnt = 0; s_reg = 16'h0; s_wel = 1'b0; s_cmask = cmask;
    pulse_start(a4, d, r);
    // one cycle after the start edge
    check(!pass && !fail, "R8 clear on start", {pass, fail}, 0);
    if (!valid) begin
      check(err == 1'b1, "R5 err pulse", err, 1);
      @(negedge clk);
      check(err == 1'b0, "R5 err single", err, 0);
      for (int i = 0; i < 30; i++) begin
        if (done) check(1'b0, "R5 no done", 1, 0);
        @(negedge clk);
      end
      check(f_cnt == 0, "R5 no frame", f_cnt, 0);
      return;
    end
    check(err == 1'b0, "R5 no err on valid", err, 0);
    wait_done(cyc, wide);
    check(cyc >= 0, "R9 done seen", cyc, 1);
    check(!wide, "R9 done one cycle", wide, 0);
    check(f_cnt == 3, "R1 frame count", f_cnt, 3);
    check(f_op[0] == 8'h06 && f_len[0] == 8, "R1 wren frame", {f_op[0], 8'(f_len[0])}, 16'h0608);
    check(f_op[1] == 8'hB1 && f_len[1] == 24, "R1 R6 write frame", {f_op[1], 8'(f_len[1])}, 16'hB118);
    check(f_op[2] == 8'hB5 && f_len[2] == 24, "R1 R7 read frame", {f_op[2], 8'(f_len[2])}, 16'hB518);
    check(s_reg[15:9] == 7'b1110111 && s_reg[3:0] == 4'hF, "R2 fixed bits", s_reg, ew);
    check(s_reg[8] == ~a4, "R3 addr bit", s_reg[8], ~a4);
    check(s_reg[7:4] == ew[7:4], "R4 dummy code", s_reg[7:4], ew[7:4]);
    check(s_reg == ew, "R6 word stored", s_reg, ew);
    if (cmask == 16'h0)
      check(pass && !fail, "R7 R8 pass", {pass, fail}, 2);
    else
      check(!pass && fail, "R8 fail on mismatch", {pass, fail}, 1);
    repeat (5) @(negedge clk);
    check((pass || fail) && !(pass && fail), "R8 held", {pass, fail}, cmask == 0 ? 2 : 1);
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    f_cnt = 0; s_wel = 1'b0; s_reg = 16'h0;
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && !done && !pass && !fail && !err, "R13 reset state",
          {cs_n, sclk, done, pass, fail, err}, 6'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int a = 0; a < 2; a++)
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < (1 << DREQ_W); r++)
          run_one(a[0], d[0], r, 16'h0);

    run_one(1'b0, 1'b0, 9, 16'h0100);
    run_one(1'b1, 1'b1, 3, 16'h0001);
    run_one(1'b0, 1'b1, 0, 16'h8000);

    // R12: start while busy
    begin
      int cyc;
      bit wide;
      f_cnt = 0; s_reg = 16'h0; s_cmask = 16'h0;
      pulse_start(1'b0, 1'b0, 5);
      repeat (40) @(negedge clk);
      pulse_start(1'b1, 1'b1, 2);
      wait_done(cyc, wide);
      repeat (200) @(negedge clk);
      check(f_cnt == 3, "R12 no extra frames", f_cnt, 3);
      check(s_reg == exp_word(1'b0, 1'b0, 5), "R12 word unchanged", s_reg, exp_word(1'b0, 1'b0, 5));
    end

    check(min_gap >= GAP_CYCLES, "R10 cs gap", min_gap, GAP_CYCLES);
    check(mosi_viol == 0, "R11 mosi stable", mosi_viol, 0);
    check(idle_viol == 0, "R11 sclk idle low", idle_viol, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule